// File: doc/BRIEF.md
# Serial-Bus Terminal to Memory-Master Bridge

This block is the digital core of a passive slave terminal on a redundant command/response serial bus. It receives words that a line decoder has already recovered. Each word arrives with a tag that says whether it is a command word or a data word, and with a flag that says whether its parity was good. The block turns each message addressed to it into single-word read or write transfers on a memory-mapped master port that uses a wait-request handshake. It returns a reply word, and for reads also the fetched words, toward the line encoder.

The terminal never starts traffic by itself, so at most one message is ever being served. A single one-word buffer serves every frame type. A receive command carries controller-to-terminal data, and its data words become memory writes. A transmit command asks for terminal-to-controller data, and its words are fetched by memory reads. The command's subaddress and a running word index together form the memory address. When the block sends a reply word that carries a flag, it raises a one-cycle interrupt. The interrupt number names the bit position of that flag.

Top module: `rt_mem_bridge`

## Requirements
- R1: A word is taken as a command only if `rx_is_cmd`=1, `rx_par_ok`=1 and its bits [15:11] equal `term_addr`. A command that fails any of these causes no memory transfer and no reply.
- R2: The command layout is [15:11] terminal address, [10] direction (1 = transmit), [9:5] subaddress and [4:0] word count. A word count of 0 stands for 32 words.
- R3: In a receive command, the k-th data word (counting from 0) becomes one write of that word to address {subaddress, k[4:0]}. Writes are issued in arrival order.
- R4: In a transmit command, a reply word is sent first. Then the block reads addresses {subaddress, k} for k = 0 to count-1, and each read result is sent as a data word (`tx_is_status`=0) in the same order.
- R5: `m_read` and `m_write` are never high together. A read or write stays asserted, with its address and write data unchanged, until a cycle in which `m_waitrequest` is low.
- R6: The reply word holds `term_addr` in [15:11], a message-error flag in [10] and a receive-complete flag in [1]. All other bits are 0. After a receive command whose writes all completed, a reply is sent with only the receive-complete flag set.
- R7: During a receive command, a data word with bad parity or any command word ends the message. That word and every later word cause no write. The reply has only the message-error flag set.
- R8: If a data word arrives while the previous write is still stalled by `m_waitrequest`, the message ends. The stalled write still completes, and only after that is a reply with the message-error flag sent. A data word that arrives in the very cycle the previous write completes is accepted.
- R9: `irq` pulses for one cycle, together with a reply word, when that word has any flag set. `irq_num` then gives the highest set flag position (10 for message error, 1 for receive complete). At all other times `irq_num` is 0.
- R10: Data words that arrive while idle, and any word that arrives while a transmit command is being served, are ignored.
- R11: After reset, `m_read`, `m_write`, `tx_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_addr | input | 5 | This terminal's bus address |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_word | input | 16 | Received word |
| rx_is_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| rx_par_ok | input | 1 | Parity of the received word was correct |
| m_address | output | 10 | Memory word address {subaddress, index} |
| m_read | output | 1 | Memory read request |
| m_write | output | 1 | Memory write request |
| m_writedata | output | 16 | Memory write data |
| m_readdata | input | 16 | Memory read data, valid when a read completes |
| m_waitrequest | input | 1 | Memory stalls the current request |
| irq | output | 1 | One-cycle interrupt alongside a flagged reply |
| irq_num | output | 4 | Highest flag position in that reply |
| tx_valid | output | 1 | A word to transmit is present this cycle |
| tx_word | output | 16 | Word to transmit |
| tx_is_status | output | 1 | 1 = reply word, 0 = data word |

## Verification
The cycle of interest is the one in which a new data word arrives in the same cycle the previous memory write is either finishing or still stalled. That one cycle decides between the normal path (R3) and the overrun abort (R8). One directed case keeps the wait-request high and sends two data words back to back. It is judged correct if exactly one write and a message-error reply come out. A second case keeps the wait-request low and streams data words back to back, so that every write completes in the same cycle the next word lands. It is judged correct if all writes and a receive-complete reply come out. Random bounded stalls across many messages test the same boundary from both sides.

// File: rtl/rtb_pkg.sv
`timescale 1ns/1ps
package rtb_pkg;
    localparam int WORD_W     = 16;
    localparam int TA_W       = 5;
    localparam int SA_W       = 5;
    localparam int WC_W       = 5;
    localparam int ADDR_W     = SA_W + WC_W;
    localparam int CNT_W      = WC_W + 1;
    localparam int FLAG_W     = WORD_W - TA_W;
    localparam int NUM_W      = $clog2(FLAG_W);
    localparam int ME_BIT     = 10;
    localparam int RXDONE_BIT = 1;

    // command word fields, most significant first
    typedef struct packed {
        logic [TA_W-1:0] ta;
        logic            xmit;
        logic [SA_W-1:0] sa;
        logic [WC_W-1:0] wc;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RECV,
        SQ_DRAIN,
        SQ_SEND
    } seq_t;

    typedef struct packed {
        logic go;
        logic msg_err;
        logic rx_done;
    } rep_req_t;

    function automatic logic [CNT_W-1:0] wc_to_len(input logic [WC_W-1:0] wc);
        if (wc == '0)
            wc_to_len = CNT_W'(1 << WC_W);
        else
            wc_to_len = {1'b0, wc};
    endfunction

    function automatic logic [WORD_W-1:0] make_status(input logic [TA_W-1:0] ta,
                                                      input logic me,
                                                      input logic done);
        logic [FLAG_W-1:0] fl;
        fl             = '0;
        fl[ME_BIT]     = me;
        fl[RXDONE_BIT] = done;
        make_status    = {ta, fl};
    endfunction

    function automatic logic [NUM_W-1:0] top_flag(input logic [FLAG_W-1:0] f);
        top_flag = '0;
        for (int i = 0; i < FLAG_W; i++)
            if (f[i]) top_flag = NUM_W'(i);
    endfunction
endpackage

// File: rtl/rtb_cmd_decode.sv
`timescale 1ns/1ps
module rtb_cmd_decode
    import rtb_pkg::*;
(
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_is_cmd,
    input  logic              rx_par_ok,
    input  logic [TA_W-1:0]   term_addr,
    output logic              cmd_hit,
    output logic              data_ok,
    output logic              cmd_xmit,
    output logic [SA_W-1:0]   cmd_sa,
    output logic [CNT_W-1:0]  cmd_len
);
    cmd_t f;

    always_comb begin
        f        = cmd_t'(rx_word);
        cmd_hit  = rx_valid && rx_is_cmd && rx_par_ok && (f.ta == term_addr);
        data_ok  = rx_valid && !rx_is_cmd && rx_par_ok;
        cmd_xmit = f.xmit;
        cmd_sa   = f.sa;
        cmd_len  = wc_to_len(f.wc);
    end
endmodule

// File: rtl/rtb_mem_master.sv
`timescale 1ns/1ps
module rtb_mem_master
    import rtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [WORD_W-1:0] go_data,
    input  logic              m_waitrequest,
    output logic [ADDR_W-1:0] m_address,
    output logic              m_read,
    output logic              m_write,
    output logic [WORD_W-1:0] m_writedata,
    output logic              busy,
    output logic              xfer_done
);
    assign busy      = m_read | m_write;
    assign xfer_done = busy & ~m_waitrequest;

    // a new request may replace one that completes in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            m_read      <= 1'b0;
            m_write     <= 1'b0;
            m_address   <= '0;
            m_writedata <= '0;
        end else if (wr_go || rd_go) begin
            m_write   <= wr_go;
            m_read    <= rd_go;
            m_address <= go_addr;
            if (wr_go) m_writedata <= go_data;
        end else if (xfer_done) begin
            m_write <= 1'b0;
            m_read  <= 1'b0;
        end
    end
endmodule

// File: rtl/rtb_seq.sv
`timescale 1ns/1ps
module rtb_seq
    import rtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              cmd_hit,
    input  logic              data_ok,
    input  logic              cmd_xmit,
    input  logic [SA_W-1:0]   cmd_sa,
    input  logic [CNT_W-1:0]  cmd_len,
    input  logic              busy,
    input  logic              xfer_done,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] go_addr,
    output rep_req_t          rep,
    output logic              dat_go
);
    seq_t             state, nxt;
    logic [SA_W-1:0]  sa_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stalled;

    assign stalled = busy && !xfer_done;

    always_comb begin
        nxt     = state;
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        dat_go  = 1'b0;
        rep     = '0;
        go_addr = {sa_q, cnt_q[WC_W-1:0]};
        case (state)
            SQ_IDLE: begin
                if (cmd_hit) begin
                    if (cmd_xmit) begin
                        nxt     = SQ_SEND;
                        rd_go   = 1'b1;
                        go_addr = {cmd_sa, {WC_W{1'b0}}};
                        rep.go  = 1'b1;
                    end else begin
                        nxt = SQ_RECV;
                    end
                end
            end
            SQ_RECV: begin
                if (rx_valid) begin
                    if (!data_ok || cnt_q == len_q || stalled) begin
                        if (stalled) begin
                            nxt = SQ_DRAIN;
                        end else begin
                            rep.go      = 1'b1;
                            rep.msg_err = 1'b1;
                            nxt         = SQ_IDLE;
                        end
                    end else begin
                        wr_go = 1'b1;
                    end
                end else if (xfer_done && cnt_q == len_q) begin
                    rep.go      = 1'b1;
                    rep.rx_done = 1'b1;
                    nxt         = SQ_IDLE;
                end
            end
            SQ_DRAIN: begin
                if (xfer_done) begin
                    rep.go      = 1'b1;
                    rep.msg_err = 1'b1;
                    nxt         = SQ_IDLE;
                end
            end
            SQ_SEND: begin
                if (xfer_done) begin
                    dat_go = 1'b1;
                    if (cnt_q != len_q) rd_go = 1'b1;
                    else                nxt   = SQ_IDLE;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            sa_q  <= '0;
            len_q <= '0;
            cnt_q <= '0;
        end else begin
            state <= nxt;
            if (state == SQ_IDLE && cmd_hit) begin
                sa_q  <= cmd_sa;
                len_q <= cmd_len;
                cnt_q <= cmd_xmit ? CNT_W'(1) : '0;
            end else if (wr_go || rd_go) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/rtb_reply.sv
`timescale 1ns/1ps
module rtb_reply
    import rtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TA_W-1:0]   term_addr,
    input  rep_req_t          rep,
    input  logic              dat_go,
    input  logic [WORD_W-1:0] rd_word,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_is_status,
    output logic              irq,
    output logic [NUM_W-1:0]  irq_num
);
    logic [WORD_W-1:0] st_word;
    logic [FLAG_W-1:0] st_flags;

    always_comb begin
        st_word  = make_status(term_addr, rep.msg_err, rep.rx_done);
        st_flags = st_word[FLAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid     <= 1'b0;
            tx_word      <= '0;
            tx_is_status <= 1'b0;
            irq          <= 1'b0;
            irq_num      <= '0;
        end else begin
            tx_valid     <= rep.go | dat_go;
            tx_is_status <= rep.go;
            irq          <= 1'b0;
            irq_num      <= '0;
            if (rep.go) begin
                tx_word <= st_word;
                irq     <= |st_flags;
                irq_num <= top_flag(st_flags);
            end else if (dat_go) begin
                tx_word <= rd_word;
            end
        end
    end
endmodule

// File: rtl/rt_mem_bridge.sv
`timescale 1ns/1ps
module rt_mem_bridge
    import rtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TA_W-1:0]   term_addr,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_is_cmd,
    input  logic              rx_par_ok,
    output logic [ADDR_W-1:0] m_address,
    output logic              m_read,
    output logic              m_write,
    output logic [WORD_W-1:0] m_writedata,
    input  logic [WORD_W-1:0] m_readdata,
    input  logic              m_waitrequest,
    output logic              irq,
    output logic [NUM_W-1:0]  irq_num,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_is_status
);
    logic              cmd_hit, data_ok, cmd_xmit;
    logic [SA_W-1:0]   cmd_sa;
    logic [CNT_W-1:0]  cmd_len;
    logic              busy, xfer_done, wr_go, rd_go, dat_go;
    logic [ADDR_W-1:0] go_addr;
    rep_req_t          rep;

    rtb_cmd_decode u_dec (
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .rx_is_cmd (rx_is_cmd),
        .rx_par_ok (rx_par_ok),
        .term_addr (term_addr),
        .cmd_hit   (cmd_hit),
        .data_ok   (data_ok),
        .cmd_xmit  (cmd_xmit),
        .cmd_sa    (cmd_sa),
        .cmd_len   (cmd_len)
    );

    rtb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .cmd_hit   (cmd_hit),
        .data_ok   (data_ok),
        .cmd_xmit  (cmd_xmit),
        .cmd_sa    (cmd_sa),
        .cmd_len   (cmd_len),
        .busy      (busy),
        .xfer_done (xfer_done),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .go_addr   (go_addr),
        .rep       (rep),
        .dat_go    (dat_go)
    );

    rtb_mem_master u_mm (
        .clk           (clk),
        .rst           (rst),
        .wr_go         (wr_go),
        .rd_go         (rd_go),
        .go_addr       (go_addr),
        .go_data       (rx_word),
        .m_waitrequest (m_waitrequest),
        .m_address     (m_address),
        .m_read        (m_read),
        .m_write       (m_write),
        .m_writedata   (m_writedata),
        .busy          (busy),
        .xfer_done     (xfer_done)
    );

    rtb_reply u_rep (
        .clk          (clk),
        .rst          (rst),
        .term_addr    (term_addr),
        .rep          (rep),
        .dat_go       (dat_go),
        .rd_word      (m_readdata),
        .tx_valid     (tx_valid),
        .tx_word      (tx_word),
        .tx_is_status (tx_is_status),
        .irq          (irq),
        .irq_num      (irq_num)
    );
endmodule

// File: rtl/rtb_bridge_chk.sv
`timescale 1ns/1ps
module rtb_bridge_chk
    import rtb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TA_W-1:0]   term_addr,
    input logic [ADDR_W-1:0] m_address,
    input logic              m_read,
    input logic              m_write,
    input logic [WORD_W-1:0] m_writedata,
    input logic              m_waitrequest,
    input logic              irq,
    input logic [NUM_W-1:0]  irq_num,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_is_status
);
    // R5
    no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(m_read && m_write));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        m_write && m_waitrequest |=> m_write && $stable(m_address) && $stable(m_writedata));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        m_read && m_waitrequest |=> m_read && $stable(m_address));

    // R9
    irq_with_reply_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> tx_valid && tx_is_status);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9
    irq_num_err_chk: assert property (@(posedge clk) disable iff (rst)
        irq && tx_word[ME_BIT] |-> irq_num == NUM_W'(ME_BIT));

    // R9
    irq_num_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !irq |-> irq_num == '0);

    // R6
    reply_addr_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_is_status |-> tx_word[WORD_W-1:WORD_W-TA_W] == $past(term_addr));
endmodule

bind rt_mem_bridge rtb_bridge_chk u_chk (.*);

// File: tb/sim_rt_mem_bridge.sv
`timescale 1ns/1ps
module sim_rt_mem_bridge;
    import rtb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [TA_W-1:0]   term_addr;
    logic              rx_valid, rx_is_cmd, rx_par_ok;
    logic [WORD_W-1:0] rx_word;
    logic [ADDR_W-1:0] m_address;
    logic              m_read, m_write, m_waitrequest;
    logic [WORD_W-1:0] m_writedata, m_readdata;
    logic              irq, tx_valid, tx_is_status;
    logic [NUM_W-1:0]  irq_num;
    logic [WORD_W-1:0] tx_word;

    always #2 clk = ~clk;

    rt_mem_bridge u0 (.*);

    logic [WORD_W-1:0] mem [0:(1<<ADDR_W)-1];
    assign m_readdata = mem[m_address];

    int n_vec = 0, n_bad = 0;
    int wait_mode = 0, stall_run = 0, hold_err = 0;
    int wr_n = 0, tx_n = 0, exp_wr_n = 0, exp_tx_n = 0;
    logic [25:0] wr_log [0:63];
    logic [25:0] exp_wr [0:63];
    logic [21:0] tx_log [0:63];
    logic [21:0] exp_tx [0:63];
    logic prev_wst, prev_rst;
    logic [ADDR_W-1:0] prev_a;
    logic [WORD_W-1:0] prev_d;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory model and observation, away from the rising edge
    always @(negedge clk) begin
        if (wait_mode == 0) begin
            if (stall_run >= 2) m_waitrequest = 1'b0;
            else m_waitrequest = ($urandom % 3 == 0);
            stall_run = m_waitrequest ? stall_run + 1 : 0;
        end else begin
            m_waitrequest = (wait_mode == 1);
        end
        #1;
        if (!rst) begin
            if (m_read && m_write) hold_err++;
            if (prev_wst && !(m_write && m_address == prev_a && m_writedata == prev_d)) hold_err++;
            if (prev_rst && !(m_read && m_address == prev_a)) hold_err++;
            prev_wst = m_write && m_waitrequest;
            prev_rst = m_read && m_waitrequest;
            prev_a   = m_address;
            prev_d   = m_writedata;
            if (m_write && !m_waitrequest) begin
                if (wr_n < 64) wr_log[wr_n] = {m_address, m_writedata};
                wr_n++;
                mem[m_address] = m_writedata;
            end
            if (tx_valid) begin
                if (tx_n < 64) tx_log[tx_n] = {irq, irq_num, tx_is_status, tx_word};
                tx_n++;
            end
        end
    end

    function automatic logic [15:0] mk_cmd(input logic [4:0] ta, input logic xm,
                                           input logic [4:0] sa, input logic [4:0] wc);
        return {ta, xm, sa, wc};
    endfunction

    task automatic put(input logic [15:0] w, input logic c, input logic p);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = w; rx_is_cmd = c; rx_par_ok = p;
    endtask

    task automatic quiet();
        @(negedge clk);
        rx_valid = 1'b0; rx_word = '0; rx_is_cmd = 1'b0; rx_par_ok = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr_n = 0; tx_n = 0; exp_wr_n = 0; exp_tx_n = 0;
    endtask

    task automatic add_status(input logic me, input logic done);
        logic [3:0] num;
        num = me ? 4'd10 : (done ? 4'd1 : 4'd0);
        exp_tx[exp_tx_n] = {me | done, num, 1'b1, term_addr, me, 8'h00, done, 1'b0};
        exp_tx_n++;
    endtask

    task automatic judge(input string req);
        check(wr_n == exp_wr_n, {req, " write count"}, 32'(wr_n), 32'(exp_wr_n));
        for (int i = 0; i < exp_wr_n; i++)
            if (i < wr_n) check(wr_log[i] == exp_wr[i], {req, " write"}, 32'(wr_log[i]), 32'(exp_wr[i]));
        check(tx_n == exp_tx_n, {req, " reply count"}, 32'(tx_n), 32'(exp_tx_n));
        for (int i = 0; i < exp_tx_n; i++)
            if (i < tx_n) check(tx_log[i] == exp_tx[i], {req, " R6 R9 reply word"}, 32'(tx_log[i]), 32'(exp_tx[i]));
        check(hold_err == 0, "R5 handshake", 32'(hold_err), 32'd0);
    endtask

    // receive message; bad_at<0 means no abort, bad_kind 0 = parity, 1 = command word
    task automatic run_rx(input logic [4:0] sa, input logic [4:0] wc, input int bad_at, input int bad_kind, input string req);
        int len; logic [15:0] d; logic me;
        len = (wc == 5'd0) ? 32 : int'(wc);
        clear_all();
        put(mk_cmd(term_addr, 1'b0, sa, wc), 1'b1, 1'b1); quiet(); idle(3);
        me = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (i == bad_at) begin
                me = 1'b1;
                if (bad_kind == 0) put(16'($urandom), 1'b0, 1'b0);
                else put(mk_cmd(term_addr, 1'b0, 5'($urandom), 5'($urandom)), 1'b1, 1'b1);
                quiet();
                break;
            end
            d = 16'($urandom);
            put(d, 1'b0, 1'b1); quiet();
            exp_wr[exp_wr_n] = {sa, 5'(i), d}; exp_wr_n++;
            idle(4);
        end
        add_status(me, !me);
        idle(20);
        judge(req);
    endtask

    task automatic run_tx(input logic [4:0] sa, input logic [4:0] wc, input bit noise, input string req);
        int len;
        len = (wc == 5'd0) ? 32 : int'(wc);
        clear_all();
        add_status(1'b0, 1'b0);
        for (int i = 0; i < len; i++) begin
            exp_tx[exp_tx_n] = {1'b0, 4'd0, 1'b0, mem[{sa, 5'(i)}]};
            exp_tx_n++;
        end
        put(mk_cmd(term_addr, 1'b1, sa, wc), 1'b1, 1'b1); quiet();
        if (noise) begin
            put(16'hBEEF, 1'b0, 1'b1); quiet();
            put(mk_cmd(term_addr, 1'b0, sa, 5'd3), 1'b1, 1'b1); quiet();
        end
        idle(len * 4 + 20);
        judge(req);
    endtask

    task automatic run_ignore(input logic [15:0] w, input logic c, input logic p, input string req);
        clear_all();
        put(w, c, p); quiet(); idle(2);
        put(16'h1234, 1'b0, 1'b1); quiet(); idle(4);
        put(16'h4321, 1'b0, 1'b1); quiet();
        idle(20);
        judge(req);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: act=%h exp=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d0, d1;
        int len, bad, r;
        void'($urandom(32'hC0DE_0021));
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 16'(i * 37) ^ 16'h5A5A;
        term_addr = 5'h0B;
        rx_valid = 1'b0; rx_word = '0; rx_is_cmd = 1'b0; rx_par_ok = 1'b0;
        m_waitrequest = 1'b0;
        prev_wst = 1'b0; prev_rst = 1'b0; prev_a = '0; prev_d = '0;
        rst = 1'b1;
        idle(5);
        rst = 1'b0;
        @(negedge clk); #2;
        // R11
        check(!m_read && !m_write && !tx_valid && !irq, "R11 reset",
              {28'd0, m_read, m_write, tx_valid, irq}, 32'd0);

        // R1 wrong terminal address, bad-parity command; R10 stray data while idle
        run_ignore(mk_cmd(term_addr ^ 5'h01, 1'b0, 5'h02, 5'd2), 1'b1, 1'b1, "R1 address mismatch");
        run_ignore(mk_cmd(term_addr, 1'b0, 5'h02, 5'd2), 1'b1, 1'b0, "R1 command parity");
        run_ignore(16'hA5A5, 1'b0, 1'b1, "R10 idle data");

        // R2 word count 0 means 32, both directions
        wait_mode = 0;
        run_rx(5'h1F, 5'd0, -1, 0, "R2 R3 full receive");
        run_tx(5'h1F, 5'd0, 1'b0, "R2 R4 full transmit");

        // R7 parity abort mid message and command-word abort
        run_rx(5'h04, 5'd6, 3, 0, "R7 parity abort");
        run_rx(5'h05, 5'd4, 0, 1, "R7 command abort");

        // R10 words during transmit are ignored
        wait_mode = 2;
        run_tx(5'h06, 5'd8, 1'b1, "R10 transmit noise");

        // R8 back-to-back words with writes finishing on the arrival cycle
        clear_all();
        put(mk_cmd(term_addr, 1'b0, 5'h07, 5'd4), 1'b1, 1'b1); quiet(); idle(2);
        for (int i = 0; i < 4; i++) begin
            d0 = 16'($urandom);
            put(d0, 1'b0, 1'b1);
            exp_wr[exp_wr_n] = {5'h07, 5'(i), d0}; exp_wr_n++;
        end
        quiet();
        add_status(1'b0, 1'b1);
        idle(20);
        judge("R8 coincident completion");

        // R8 overrun: second word while the first write is stalled
        clear_all();
        wait_mode = 1;
        put(mk_cmd(term_addr, 1'b0, 5'h03, 5'd4), 1'b1, 1'b1); quiet(); idle(2);
        d0 = 16'($urandom); d1 = 16'($urandom);
        put(d0, 1'b0, 1'b1); put(d1, 1'b0, 1'b1); quiet();
        idle(6);
        wait_mode = 2;
        idle(12);
        exp_wr[0] = {5'h03, 5'd0, d0}; exp_wr_n = 1;
        add_status(1'b1, 1'b0);
        judge("R8 overrun");

        // random mix under bounded stalls
        wait_mode = 0;
        idle(4);
        for (int k = 0; k < 30; k++) begin
            r = $urandom % 10;
            if (r == 0) begin
                run_ignore(mk_cmd(term_addr ^ 5'(1 + $urandom % 31), 1'($urandom), 5'($urandom), 5'($urandom)),
                           1'b1, 1'b1, "R1 random mismatch");
            end else if (r == 1) begin
                run_ignore(mk_cmd(term_addr, 1'b0, 5'($urandom), 5'($urandom)), 1'b1, 1'b0, "R1 random parity");
            end else if (r < 6) begin
                d0 = 16'($urandom);
                len = (d0[4:0] == 5'd0) ? 32 : int'(d0[4:0]);
                bad = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
                run_rx(d0[9:5], d0[4:0], bad, int'($urandom % 2), "R3 R7 random receive");
            end else begin
                d0 = 16'($urandom);
                run_tx(d0[9:5], d0[4:0], 1'b0, "R4 random transmit");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule